// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block sits behind the slicer and squelch stage of a 10 Mb/s twisted-pair receiver. It takes the line as a one-bit level that is already sampled at eight times the bit rate, together with a flag that says the signal has passed squelch. It recovers the NRZ data and hands it to the receive interface as 4-bit nibbles. Carrier sense rises on the first edge seen while squelch is met. That edge is taken as the centre of the first bit cell. From then on, bit timing is tracked from mid-cell transition to mid-cell transition.

Each bit is taken from the direction of its mid-cell transition. Transitions at cell boundaries are filtered out, because an edge counts only inside a window that opens three quarters of a bit after the previous centre and closes at five quarters. When no centre transition arrives for one and a half bit times, the frame has ended. Carrier sense then drops, and any partial nibble is discarded. Losing squelch ends reception at once.

Top module: `manch_rx_decoder`

## Requirements
- R1: After reset, crs_o, rx_dv_o and rxd_o are all 0.
- R2: While squelch_ok_i is 0, crs_o and rx_dv_o stay 0 whatever line_i does.
- R3: With squelch_ok_i at 1 and no frame in progress, the first change of line_i makes crs_o read 1 after the clock edge that samples the changed level. That edge counts as the mid-cell transition of the frame's first bit.
- R4: A mid-cell transition from 0 to 1 decodes as bit 1, and one from 1 to 0 decodes as bit 0.
- R5: A transition that comes fewer than 6 sample clocks after the last accepted mid-cell transition is ignored.
- R6: A transition 6 to 10 sample clocks after the last accepted one is accepted as a mid-cell transition. One at 11 clocks is ignored.
- R7: When 12 sample clocks pass after the last accepted mid-cell transition with no new one, crs_o reads 0 after that 12th clock. Bits not yet forming a full nibble are dropped.
- R8: Bits fill a nibble LSB first: the first bit goes to rxd_o[0] and the fourth to rxd_o[3]. rx_dv_o is high for exactly one clock, following the clock that accepts the fourth bit, and rxd_o changes only together with rx_dv_o.
- R9: If squelch_ok_i falls during a frame, crs_o reads 0 after the clock edge that samples the low flag. No nibble is produced from bits that were left incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 8x the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| squelch_ok_i | input | 1 | Input signal has met the squelch threshold |
| line_i | input | 1 | Sliced line level, one sample per clock |
| crs_o | output | 1 | Carrier sense |
| rxd_o | output | 4 | Received nibble, bit 0 is the earliest bit |
| rx_dv_o | output | 1 | One-clock strobe marking a new nibble on rxd_o |

## Verification
Every result has a fixed delay counted in sampled line positions:
- Carrier sense rises at the clock that samples the first edge.
- A nibble strobe appears at the clock that samples the fourth bit's mid-cell transition.
- Carrier sense falls exactly 12 samples after the last centre transition, or at the clock that samples a lost squelch flag.

The bench numbers every driven sample. It reads the outputs at the falling edge before driving the next sample, so each observation is tied to the index of the last sample captured. Each frame's expected rise index, fall index and nibble list are computed from the bit list and cell lengths it was built from, and the observations are compared against those values.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;
  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;

  function automatic int win_lo(input int os);
    return (os * 3) / 4;
  endfunction

  function automatic int win_hi(input int os);
    return (os * 5) / 4;
  endfunction

  function automatic int eof_limit(input int os);
    return (os * 3) / 2;
  endfunction
endpackage

// File: rtl/manch_edge_det.sv
module manch_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o,
  output logic level_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign edge_o  = line_i ^ line_q;
  assign level_o = line_i;
endmodule

// File: rtl/manch_cell_timer.sv
module manch_cell_timer #(
  parameter int CNT_W   = 4,
  parameter int WIN_LO  = 6,
  parameter int WIN_HI  = 10,
  parameter int EOF_CNT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic in_window_o,
  output logic timeout_o
);
  logic [CNT_W-1:0] cnt_q;

  // cnt_q holds the number of clocks since the last restart; saturates at EOF_CNT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i)                 cnt_q <= CNT_W'(1);
    else if (cnt_q != CNT_W'(EOF_CNT))  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign in_window_o = (cnt_q >= CNT_W'(WIN_LO)) && (cnt_q <= CNT_W'(WIN_HI));
  assign timeout_o   = (cnt_q == CNT_W'(EOF_CNT));
endmodule

// File: rtl/manch_nibble_pack.sv
module manch_nibble_pack #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [NIB_W-1:0] data_o,
  output logic             dv_o
);
  localparam int CW = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [NIB_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;
  logic [NIB_W-1:0] sh_next;

  generate
    if (NIB_W > 1) begin : g_shift
      assign sh_next = {bit_i, sh_q[NIB_W-1:1]};
    end else begin : g_single
      assign sh_next = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      data_o <= '0;
      dv_o   <= 1'b0;
    end else if (flush_i) begin
      cnt_q <= '0;
      dv_o  <= 1'b0;
    end else if (bit_vld_i) begin
      sh_q <= sh_next;
      if (cnt_q == CW'(NIB_W - 1)) begin
        cnt_q  <= '0;
        data_o <= sh_next;
        dv_o   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
        dv_o  <= 1'b0;
      end
    end else begin
      dv_o <= 1'b0;
    end
  end
endmodule

// File: rtl/manch_rx_decoder.sv
module manch_rx_decoder
  import manch_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int NIB_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             squelch_ok_i,
  input  logic             line_i,
  output logic             crs_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o
);
  localparam int WIN_LO  = win_lo(OVERSAMPLE);
  localparam int WIN_HI  = win_hi(OVERSAMPLE);
  localparam int EOF_CNT = eof_limit(OVERSAMPLE);
  localparam int CNT_W   = $clog2(EOF_CNT + 1);

  rx_state_e state_q, state_d;
  logic edge_w, level_w, in_win_w, eof_w;
  logic lock_w, mid_w, end_w;

  manch_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .edge_o  (edge_w),
    .level_o (level_w)
  );

  manch_cell_timer #(
    .CNT_W   (CNT_W),
    .WIN_LO  (WIN_LO),
    .WIN_HI  (WIN_HI),
    .EOF_CNT (EOF_CNT)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (lock_w | mid_w),
    .in_window_o (in_win_w),
    .timeout_o   (eof_w)
  );

  // first edge after squelch is treated as the centre of bit 0
  assign lock_w = (state_q == RX_IDLE) && squelch_ok_i && edge_w;
  assign mid_w  = (state_q == RX_ACTIVE) && squelch_ok_i && edge_w && in_win_w;
  assign end_w  = !squelch_ok_i || ((state_q == RX_ACTIVE) && eof_w && !mid_w);

  always_comb begin
    state_d = state_q;
    if (!squelch_ok_i)                               state_d = RX_IDLE;
    else if (lock_w)                                 state_d = RX_ACTIVE;
    else if ((state_q == RX_ACTIVE) && eof_w && !mid_w) state_d = RX_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RX_IDLE;
    else         state_q <= state_d;
  end

  manch_nibble_pack #(
    .NIB_W (NIB_W)
  ) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (end_w),
    .bit_vld_i (lock_w | mid_w),
    .bit_i     (level_w),
    .data_o    (rxd_o),
    .dv_o      (rx_dv_o)
  );

  assign crs_o = (state_q == RX_ACTIVE);
endmodule

// File: rtl/manch_rx_decoder_chk.sv
module manch_rx_decoder_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             squelch_ok_i,
  input logic             line_i,
  input logic             crs_o,
  input logic [NIB_W-1:0] rxd_o,
  input logic             rx_dv_o
);
  assert_squelch_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !squelch_ok_i |=> (!crs_o && !rx_dv_o));

  assert_crs_needs_squelch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crs_o) |-> $past(squelch_ok_i));

  assert_no_early_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(crs_o) && squelch_ok_i) |=> crs_o);

  assert_dv_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |=> !rx_dv_o);

  assert_dv_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |-> crs_o);

  assert_rxd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_o |-> $stable(rxd_o));
endmodule

bind manch_rx_decoder manch_rx_decoder_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .squelch_ok_i (squelch_ok_i),
  .line_i       (line_i),
  .crs_o        (crs_o),
  .rxd_o        (rxd_o),
  .rx_dv_o      (rx_dv_o)
);

// File: tb/manch_rx_decoder_test.sv
`timescale 1ns/1ps
module manch_rx_decoder_test;
  localparam int EOF = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sq = 1'b0;
  logic line = 1'b0;
  logic crs, dv;
  logic [3:0] rxd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int last_idx = 0;
  int rise_idx, fall_idx, rises, got_n, dv_dbl;
  logic prev_crs = 1'b0;
  logic prev_dv = 1'b0;
  logic [3:0] got [0:31];
  logic fb [0:63];
  int fn;

  always #2.5 clk = ~clk;

  manch_rx_decoder uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .squelch_ok_i (sq),
    .line_i       (line),
    .crs_o        (crs),
    .rxd_o        (rxd),
    .rx_dv_o      (dv)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // observe outputs for the last captured sample, then drive the next one
  task automatic step(input logic l, input logic s);
    @(negedge clk);
    if (crs && !prev_crs) begin
      rises++;
      if (rise_idx < 0) rise_idx = last_idx;
    end
    if (!crs && prev_crs && fall_idx < 0) fall_idx = last_idx;
    if (dv) begin
      if (prev_dv) dv_dbl++;
      if (got_n < 32) got[got_n] = rxd;
      got_n++;
    end
    prev_crs = crs;
    prev_dv  = dv;
    line = l;
    sq   = s;
    last_idx++;
  endtask

  function automatic int pick_half(input int mode);
    case (mode)
      1:       return 3 + int'($urandom_range(2, 0));
      2:       return 3;
      3:       return 5;
      default: return 4;
    endcase
  endfunction

  function automatic logic [3:0] exp_nib(input int k);
    return {fb[4*k+3], fb[4*k+2], fb[4*k+1], fb[4*k]};
  endfunction

  task automatic fill_random(input int n);
    fn = n;
    fb[0] = 1'b1;
    for (int i = 1; i < n; i++) fb[i] = logic'($urandom_range(1, 0));
  endtask

  task automatic send_frame(input int mode, input bit sq_en, input int drop_bit,
                            input bit stretch, input string req);
    int first_mid, last_mid, drop_idx, h1, h2, h2_prev, nbits, exp_fall;
    logic s;
    first_mid = -1; last_mid = -1; drop_idx = -1; h2_prev = 4;
    rise_idx = -1; fall_idx = -1; rises = 0; got_n = 0; dv_dbl = 0;
    for (int j = 0; j < fn; j++) begin
      s  = sq_en && (drop_bit < 0 || j < drop_bit);
      if (j == drop_bit) drop_idx = last_idx + 1;
      h1 = pick_half(mode);
      h2 = pick_half(mode);
      if (stretch && j == fn - 1) h1 = (EOF - 1) - h2_prev;
      for (int k = 0; k < h1; k++) step(!fb[j], s);
      step(fb[j], s);
      if (j == 0) first_mid = last_idx;
      if (!(stretch && j == fn - 1)) last_mid = last_idx;
      for (int k = 0; k < h2 - 1; k++) step(fb[j], s);
      h2_prev = h2;
    end
    for (int k = 0; k < 24; k++) step(1'b0, sq_en && drop_bit < 0);

    if (!sq_en) begin
      chk(rises == 0, "R2", "crs rises with squelch low", rises, 0);
      chk(got_n == 0, "R2", "nibbles with squelch low", got_n, 0);
    end else begin
      nbits    = (drop_bit >= 0) ? drop_bit : (stretch ? fn - 1 : fn);
      exp_fall = (drop_bit >= 0) ? drop_idx : last_mid + EOF;
      chk(rise_idx == first_mid, "R3", "crs rise sample", rise_idx, first_mid);
      chk(rises == 1, "R3", "crs rise count", rises, 1);
      if (drop_bit >= 0)
        chk(fall_idx == exp_fall, "R9", "crs fall on squelch loss", fall_idx, exp_fall);
      else if (stretch)
        chk(fall_idx == exp_fall, "R6", "late edge ignored, fall sample", fall_idx, exp_fall);
      else
        chk(fall_idx == exp_fall, "R7", "crs fall sample", fall_idx, exp_fall);
      chk(got_n == nbits / 4, (drop_bit >= 0) ? "R9" : "R7", "nibble count", got_n, nbits / 4);
      chk(dv_dbl == 0, "R8", "rx_dv wider than one clock", dv_dbl, 0);
      for (int k = 0; k < got_n && k < nbits / 4 && k < 32; k++)
        chk(got[k] == exp_nib(k), req, "nibble value (R8 order)", int'(got[k]), int'(exp_nib(k)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    sq = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(crs == 1'b0, "R1", "crs after reset", int'(crs), 0);
    chk(dv == 1'b0, "R1", "rx_dv after reset", int'(dv), 0);
    chk(rxd == 4'h0, "R1", "rxd after reset", int'(rxd), 0);
    repeat (4) step(1'b0, 1'b1);

    // fixed pattern, nominal cells
    fn = 16;
    for (int i = 0; i < 16; i++) fb[i] = logic'((32'hB2D1 >> i) & 1);
    fb[0] = 1'b1;
    send_frame(0, 1'b1, -1, 1'b0, "R4");

    // all ones: boundary edge in every cell
    fn = 12;
    for (int i = 0; i < 12; i++) fb[i] = 1'b1;
    send_frame(0, 1'b1, -1, 1'b0, "R5");

    // shortest and longest accepted spacing
    fill_random(20); send_frame(2, 1'b1, -1, 1'b0, "R6");
    fill_random(20); send_frame(3, 1'b1, -1, 1'b0, "R6");

    // squelch never met
    fill_random(16); send_frame(0, 1'b0, -1, 1'b0, "R2");

    // squelch lost during bit 6
    fill_random(16); send_frame(0, 1'b1, 6, 1'b0, "R9");

    // final centre edge 11 clocks late
    fill_random(9); fb[8] = 1'b0;
    send_frame(0, 1'b1, -1, 1'b1, "R6");

    // random frames with jitter and partial nibbles
    for (int f = 0; f < 20; f++) begin
      fill_random(int'($urandom_range(40, 8)));
      send_frame(1, 1'b1, -1, 1'b0, "R5");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule